// File: doc/BRIEF.md
# Display RAM Write Address Sequencer

This block holds the write position inside a display memory of 84 columns by 6 banks, where each location is one byte. A column coordinate (X, 0 to 83) and a bank coordinate (Y, 0 to 5) are kept in registers. An upstream command decoder can set either coordinate at any time through a strobe and a value. A downstream byte-wide RAM receives a linear byte address, a write enable and the data byte.

Each data byte is written at the address held at that moment. On the same clock edge the position moves on by one step. In horizontal order the column advances first and the bank advances when the column wraps. In vertical order the bank advances first and the column advances when the bank wraps. The order is chosen per write by a mode input, so software can fill the memory column by column or row by row without reissuing addresses.

Top module: `disp_addr_gen`

## Requirements
- R1: A synchronous active-high reset sets X to 0 and Y to 0, so `ram_addr` reads 0 after reset.
- R2: In horizontal order (`vert_mode` = 0), a write with X below 83 raises X by one and leaves Y unchanged.
- R3: In horizontal order, a write with X = 83 returns X to 0 and raises Y by one. When Y is 5 at that point, Y returns to 0, so (83,5) steps to (0,0).
- R4: In vertical order (`vert_mode` = 1), a write raises Y by one while Y is below 5. A write with Y = 5 returns Y to 0 and raises X by one, with X wrapping from 83 to 0.
- R5: During a cycle with `wr_stb` high, `ram_we` is high, `ram_wdata` equals `wr_data`, and `ram_addr` equals Y*84+X as held before that write's step.
- R6: A `set_x_stb` loads X from `set_x_val`. A value above 83 loads 83 instead. Y is not changed by it.
- R7: A `set_y_stb` loads Y from `set_y_val`. A value above 5 loads 5 instead. X is not changed by it.
- R8: When a set strobe and `wr_stb` share a cycle, the byte is written at the old address. The loaded coordinate takes the new value, and neither coordinate advances.
- R9: In a cycle with no write and no set strobe, X and Y keep their values and `ram_we` is low.
- R10: The scan order is taken from `vert_mode` in the cycle of each write, so the order can change between consecutive writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_x_stb | input | 1 | Load column coordinate |
| set_x_val | input | 7 | Column value to load |
| set_y_stb | input | 1 | Load bank coordinate |
| set_y_val | input | 3 | Bank value to load |
| vert_mode | input | 1 | 0 = horizontal order, 1 = vertical order |
| wr_stb | input | 1 | Data byte write request |
| wr_data | input | 8 | Data byte |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 9 | Linear RAM byte address Y*84+X |
| ram_wdata | output | 8 | RAM write data |
| cur_x | output | 7 | Current column coordinate |
| cur_y | output | 3 | Current bank coordinate |

## Verification
The corner that is hardest to reach is the double wrap, where both coordinates roll over on one write from (83,5). Random writes alone reach it only after hundreds of cycles in one order. The stimulus therefore loads the corner directly with clamped out-of-range values and then writes in each order. The random phase biases loads toward the last column and bank, mixes write-with-load cycles, and flips the order between writes.

// File: rtl/disp_addr_pkg.sv
package disp_addr_pkg;

    localparam int unsigned DEF_COLS   = 84;
    localparam int unsigned DEF_BANKS  = 6;
    localparam int unsigned DEF_DATA_W = 8;

    typedef enum logic {
        SCAN_HORIZ = 1'b0,
        SCAN_VERT  = 1'b1
    } scan_order_e;

    typedef struct packed {
        logic set_x;
        logic set_y;
        logic wr;
    } addr_ctl_t;

    // width needed for values 0..n-1 (at least one bit)
    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/disp_wrap_stage.sv
module disp_wrap_stage #(
    parameter int unsigned LIMIT = 84,
    parameter int unsigned W     = 7
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] inc_val,
    output logic         wraps,
    output logic [W-1:0] clamped
);
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    always_comb begin
        wraps   = (cur == TOP);
        inc_val = wraps ? '0 : cur + 1'b1;
        clamped = (load_val > TOP) ? TOP : load_val;
    end
endmodule

// File: rtl/disp_addr_step.sv
module disp_addr_step
    import disp_addr_pkg::*;
#(
    parameter int unsigned COLS  = DEF_COLS,
    parameter int unsigned BANKS = DEF_BANKS,
    parameter int unsigned XW    = idx_width(COLS),
    parameter int unsigned YW    = idx_width(BANKS)
) (
    input  logic [XW-1:0] x_now,
    input  logic [YW-1:0] y_now,
    input  logic [XW-1:0] x_load,
    input  logic [YW-1:0] y_load,
    input  scan_order_e   order,
    output logic [XW-1:0] x_step,
    output logic [YW-1:0] y_step,
    output logic [XW-1:0] x_clamped,
    output logic [YW-1:0] y_clamped
);
    logic [XW-1:0] x_inc;
    logic [YW-1:0] y_inc;
    logic          x_wrap;
    logic          y_wrap;

    disp_wrap_stage #(.LIMIT(COLS), .W(XW)) u_xstage (
        .cur      (x_now),
        .load_val (x_load),
        .inc_val  (x_inc),
        .wraps    (x_wrap),
        .clamped  (x_clamped)
    );

    disp_wrap_stage #(.LIMIT(BANKS), .W(YW)) u_ystage (
        .cur      (y_now),
        .load_val (y_load),
        .inc_val  (y_inc),
        .wraps    (y_wrap),
        .clamped  (y_clamped)
    );

    // inner coordinate always moves; outer one moves on inner wrap
    always_comb begin
        unique case (order)
            SCAN_HORIZ: begin
                x_step = x_inc;
                y_step = x_wrap ? y_inc : y_now;
            end
            SCAN_VERT: begin
                y_step = y_inc;
                x_step = y_wrap ? x_inc : x_now;
            end
            default: begin
                x_step = x_now;
                y_step = y_now;
            end
        endcase
    end
endmodule

// File: rtl/disp_addr_linear.sv
module disp_addr_linear #(
    parameter int unsigned COLS = 84,
    parameter int unsigned XW   = 7,
    parameter int unsigned YW   = 3,
    parameter int unsigned AW   = 9
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    output logic [AW-1:0] lin
);
    localparam logic [AW-1:0] STRIDE = AW'(COLS);

    always_comb begin
        lin = AW'(y) * STRIDE + AW'(x);
    end
endmodule

// File: rtl/disp_addr_gen.sv
module disp_addr_gen
    import disp_addr_pkg::*;
#(
    parameter int unsigned COLS   = DEF_COLS,
    parameter int unsigned BANKS  = DEF_BANKS,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned XW     = idx_width(COLS),
    parameter int unsigned YW     = idx_width(BANKS),
    parameter int unsigned AW     = idx_width(COLS * BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_x_stb,
    input  logic [XW-1:0]     set_x_val,
    input  logic              set_y_stb,
    input  logic [YW-1:0]     set_y_val,
    input  logic              vert_mode,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ram_we,
    output logic [AW-1:0]     ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [XW-1:0]     cur_x,
    output logic [YW-1:0]     cur_y
);
    localparam logic [XW-1:0] XMAX = XW'(COLS - 1);
    localparam logic [YW-1:0] YMAX = YW'(BANKS - 1);

    addr_ctl_t     ctl;
    scan_order_e   order;
    logic [XW-1:0] x_q, x_step, x_clamped;
    logic [YW-1:0] y_q, y_step, y_clamped;

    assign ctl   = '{set_x: set_x_stb, set_y: set_y_stb, wr: wr_stb};
    assign order = scan_order_e'(vert_mode);

    disp_addr_step #(.COLS(COLS), .BANKS(BANKS), .XW(XW), .YW(YW)) u_step (
        .x_now     (x_q),
        .y_now     (y_q),
        .x_load    (set_x_val),
        .y_load    (set_y_val),
        .order     (order),
        .x_step    (x_step),
        .y_step    (y_step),
        .x_clamped (x_clamped),
        .y_clamped (y_clamped)
    );

    // loads take priority over the post-write step
    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else if (ctl.set_x || ctl.set_y) begin
            if (ctl.set_x) x_q <= x_clamped;
            if (ctl.set_y) y_q <= y_clamped;
        end else if (ctl.wr) begin
            x_q <= x_step;
            y_q <= y_step;
        end
    end

    disp_addr_linear #(.COLS(COLS), .XW(XW), .YW(YW), .AW(AW)) u_lin (
        .x   (x_q),
        .y   (y_q),
        .lin (ram_addr)
    );

    assign ram_we    = wr_stb;
    assign ram_wdata = wr_data;
    assign cur_x     = x_q;
    assign cur_y     = y_q;

    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (cur_x == '0 && cur_y == '0));

    assert_range_x_R2: assert property (@(posedge clk) disable iff (rst)
        cur_x <= XMAX);

    assert_range_y_R3: assert property (@(posedge clk) disable iff (rst)
        cur_y <= YMAX);

    assert_vert_inner_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && vert_mode && !set_x_stb && !set_y_stb && cur_y != YMAX)
        |=> (cur_y == $past(cur_y) + 1'b1 && $stable(cur_x)));

    assert_horiz_inner_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !vert_mode && !set_x_stb && !set_y_stb && cur_x != XMAX)
        |=> (cur_x == $past(cur_x) + 1'b1 && $stable(cur_y)));

    assert_clamp_x_R6: assert property (@(posedge clk) disable iff (rst)
        (set_x_stb && !set_y_stb) |=> ($stable(cur_y) &&
            cur_x == (($past(set_x_val) > XMAX) ? XMAX : $past(set_x_val))));

    assert_clamp_y_R7: assert property (@(posedge clk) disable iff (rst)
        (set_y_stb && !set_x_stb) |=> ($stable(cur_x) &&
            cur_y == (($past(set_y_val) > YMAX) ? YMAX : $past(set_y_val))));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!wr_stb && !set_x_stb && !set_y_stb) |=> ($stable(cur_x) && $stable(cur_y)));

    assert_idle_we_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |-> !ram_we);
endmodule

// File: tb/disp_addr_gen_bench.sv
`timescale 1ns/1ps
module disp_addr_gen_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       set_x_stb, set_y_stb, vert_mode, wr_stb;
    logic [6:0] set_x_val;
    logic [2:0] set_y_val;
    logic [7:0] wr_data;
    logic       ram_we;
    logic [8:0] ram_addr;
    logic [7:0] ram_wdata;
    logic [6:0] cur_x;
    logic [2:0] cur_y;

    int checks = 0;
    int failures = 0;
    int mx = 0;
    int my = 0;

    always #2 clk = ~clk;

    disp_addr_gen u_disp_addr_gen (
        .clk(clk), .rst(rst),
        .set_x_stb(set_x_stb), .set_x_val(set_x_val),
        .set_y_stb(set_y_stb), .set_y_val(set_y_val),
        .vert_mode(vert_mode), .wr_stb(wr_stb), .wr_data(wr_data),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .cur_x(cur_x), .cur_y(cur_y)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampv(input int v, input int top);
        return (v > top) ? top : v;
    endfunction

    // one cycle of stimulus with model update and checks
    task automatic op(input bit sx, input int xv, input bit sy, input int yv,
                      input bit v, input bit w, input int d, input string tag);
        int ex, ey;
        @(negedge clk);
        set_x_stb = sx; set_x_val = 7'(xv);
        set_y_stb = sy; set_y_val = 3'(yv);
        vert_mode = v;  wr_stb = w; wr_data = 8'(d);
        #1;
        if (w) begin
            check(ram_we == 1'b1, {tag, " R5 we"}, int'(ram_we), 1);
            check(int'(ram_addr) == my * 84 + mx, {tag, " R5 addr"}, int'(ram_addr), my * 84 + mx);
            check(int'(ram_wdata) == d, {tag, " R5 data"}, int'(ram_wdata), d);
        end else begin
            check(ram_we == 1'b0, {tag, " R9 we"}, int'(ram_we), 0);
        end
        ex = mx; ey = my;
        if (sx || sy) begin
            if (sx) ex = clampv(xv, 83);
            if (sy) ey = clampv(yv, 5);
        end else if (w) begin
            if (!v) begin
                if (mx == 83) begin ex = 0; ey = (my == 5) ? 0 : my + 1; end
                else ex = mx + 1;
            end else begin
                if (my == 5) begin ey = 0; ex = (mx == 83) ? 0 : mx + 1; end
                else ey = my + 1;
            end
        end
        @(posedge clk);
        #1;
        mx = ex; my = ey;
        check(int'(cur_x) == mx, {tag, " x"}, int'(cur_x), mx);
        check(int'(cur_y) == my, {tag, " y"}, int'(cur_y), my);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1;
        set_x_stb = 0; set_y_stb = 0; vert_mode = 0; wr_stb = 0;
        set_x_val = '0; set_y_val = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(cur_x == 0 && cur_y == 0, "R1 reset coords", int'(cur_x) * 8 + int'(cur_y), 0);
        check(ram_addr == 0, "R1 reset addr", int'(ram_addr), 0);

        op(0, 0, 0, 0, 0, 1, 8'h11, "R2 h step");
        op(0, 0, 0, 0, 0, 0, 0, "R9 idle");
        op(1, 120, 0, 0, 0, 0, 0, "R6 clamp x");
        op(0, 0, 1, 7, 0, 0, 0, "R7 clamp y");
        op(0, 0, 0, 0, 0, 1, 8'hA5, "R3 double wrap h");
        op(1, 83, 1, 2, 0, 0, 0, "R6 R7 load");
        op(0, 0, 0, 0, 0, 1, 8'h3C, "R3 column wrap");
        op(1, 83, 1, 5, 1, 0, 0, "R4 setup");
        op(0, 0, 0, 0, 1, 1, 8'h5A, "R4 double wrap v");
        op(0, 0, 0, 0, 1, 1, 8'h01, "R4 v step");
        op(0, 0, 1, 5, 1, 1, 8'h77, "R8 load with write");
        op(1, 10, 0, 0, 0, 1, 8'h78, "R8 x load with write");
        op(0, 0, 0, 0, 0, 1, 8'h02, "R10 h");
        op(0, 0, 0, 0, 1, 1, 8'h03, "R10 v");

        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            bit sx = (r < 6);
            bit sy = (r >= 4 && r < 10);
            int xv = ($urandom_range(0, 1) != 0) ? $urandom_range(80, 127) : $urandom_range(0, 127);
            int yv = $urandom_range(0, 7);
            bit w  = ($urandom_range(0, 9) < 7);
            op(sx, xv, sy, yv, 1'($urandom_range(0, 1)), w, $urandom_range(0, 255), "R10 random");
        end

        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        check(cur_x == 0 && cur_y == 0, "R1 re-reset", int'(cur_x) * 8 + int'(cur_y), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule